// File: doc/BRIEF.md
# Strip Plane Peak Finder

This block examines one detector plane of 36 side-by-side strips and groups the strips into one-dimensional peaks. A strip counts as active when its 4-bit energy is strictly greater than a programmable floor. A peak is a run of active strips that touch each other. At each end, the run meets either an inactive strip or the edge of the plane. For each run, the block adds up the energies and computes an energy-weighted mean strip number. A run is reported only when its total energy is strictly greater than a second, 10-bit floor.

A scan begins with a one-cycle `start` pulse. On that pulse the block captures the packed energy vector and both floors. It then steps through the plane one strip per clock, from strip 1 to strip 36. Each accepted peak appears as a one-cycle `peak_valid` record carrying its rounded center and its energy. A one-cycle `scan_done` pulse closes the scan. The records feed a later stage that matches peaks across planes.

Top module: `strip_peak_finder`

## Requirements
- R1: A strip joins a run only if its energy is strictly greater than `thr_strip`. A strip whose energy equals or is below `thr_strip` is inactive, so a plane of strips all equal to the floor reports no peak.
- R2: Active strips that touch form a single peak. One or more inactive strips between two active groups splits them into two separate peaks.
- R3: `peak_energy` is the exact sum of the 4-bit strip energies in the run. It never wraps, and this includes a run covering all 36 strips at 15, which gives 540.
- R4: `peak_center` is the 1-based weighted mean strip number, sum(n*E)/sum(E), rounded to the nearest integer. An exact half rounds down. The result always lies in 1..36.
- R5: A run is reported only when its summed energy is strictly greater than `thr_peak`. A run whose total equals or is below the floor produces no record.
- R6: A run still active at strip 36 is closed at the plane edge, and it is reported in the same way as any other run.
- R7: Within one scan, the records come out with strictly increasing `peak_center`.
- R8: `scan_done` is high for exactly one cycle, 37 clock edges after the edge that accepted `start`. No `peak_valid` occurs in that cycle or in any later cycle of the same scan.
- R9: A `start` pulse that arrives while a scan is running is ignored. The running scan keeps its timing and its records.
- R10: Reset clears `peak_valid`, `peak_center`, `peak_energy` and `scan_done` to 0 and abandons any scan in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a scan; sampled only when idle |
| strip_energy | input | 144 | Packed strip energies, strip n in bits [4n-1:4n-4] |
| thr_strip | input | 4 | Strip activity floor (strict) |
| thr_peak | input | 10 | Peak report floor (strict) |
| peak_valid | output | 1 | A peak record is present this cycle |
| peak_center | output | 6 | Rounded weighted center strip, 1..36 |
| peak_energy | output | 10 | Summed energy of the peak |
| scan_done | output | 1 | One-cycle end-of-scan pulse |

## Verification
The assertions check on every cycle that reported records meet the report floor, that centers stay within 1..36 and rise within a scan, and that energies stay within the full-plane bound. They also check that the done pulse lasts a single cycle and never coincides with a record, and that an open run always holds a non-zero sum. Only the bench's scenarios can show the values themselves: the correct split of runs, the exact sums, the round-down on a half-strip tie, the closure of a run at strip 36, the 37-edge latency, and the handling of a start pulse that arrives mid-scan or of a reset during a scan.

// File: rtl/spf_pkg.sv
package spf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FIN  = 2'd2
    } scan_st_e;

endpackage

// File: rtl/spf_scan_ctrl.sv
module spf_scan_ctrl #(
    parameter int N_STRIPS = 36,
    parameter int IDX_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             load,
    output logic             scan_act,
    output logic             last_strip,
    output logic [IDX_W-1:0] idx,
    output logic             done
);
    import spf_pkg::*;

    typedef struct packed {
        scan_st_e         st;
        logic [IDX_W-1:0] idx;
        logic             done;
    } ctrl_t;

    ctrl_t d, q;

    assign load       = (q.st == ST_IDLE) && start;
    assign scan_act   = (q.st == ST_SCAN);
    assign last_strip = (q.idx == IDX_W'(N_STRIPS - 1));
    assign idx        = q.idx;
    assign done       = q.done;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st  = ST_SCAN;
                    d.idx = '0;
                end
            end
            ST_SCAN: begin
                if (last_strip) d.st = ST_FIN;
                else            d.idx = q.idx + 1'b1;
            end
            ST_FIN: begin
                d.done = 1'b1;
                d.st   = ST_IDLE;
                d.idx  = '0;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, idx: '0, done: 1'b0};
        else        q <= d;
    end

    // R8: the end-of-scan pulse lasts one cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the strip index stays inside the plane during a scan
    p_idx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_act |-> (idx < IDX_W'(N_STRIPS)));

endmodule

// File: rtl/spf_run_acc.sv
module spf_run_acc #(
    parameter int E_W    = 4,
    parameter int SUM_W  = 10,
    parameter int IDX_W  = 6,
    parameter int WSUM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              active,
    input  logic              at_edge,
    input  logic [E_W-1:0]    energy,
    input  logic [IDX_W-1:0]  strip_num,
    output logic              close,
    output logic [SUM_W-1:0]  tot_e,
    output logic [WSUM_W-1:0] tot_w
);
    typedef struct packed {
        logic              open;
        logic [SUM_W-1:0]  esum;
        logic [WSUM_W-1:0] wsum;
    } run_t;

    run_t d, q;

    logic [E_W-1:0]    add_e;
    logic [WSUM_W-1:0] add_w;

    always_comb begin
        add_e = active ? energy : '0;
        add_w = WSUM_W'(add_e) * WSUM_W'(strip_num);
        tot_e = q.esum + SUM_W'(add_e);
        tot_w = q.wsum + add_w;
        close = step && ((q.open && !active) || (active && at_edge));

        d = q;
        if (clear) begin
            d = '0;
        end else if (step) begin
            if (close) begin
                d = '0;
            end else if (active) begin
                d.open = 1'b1;
                d.esum = tot_e;
                d.wsum = tot_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R1: a run is open only after at least one strip above the floor, which is never zero
    p_run_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.open |-> (q.esum != '0));

endmodule

// File: rtl/spf_center.sv
module spf_center #(
    parameter int SUM_W  = 10,
    parameter int WSUM_W = 16,
    parameter int IDX_W  = 6
) (
    input  logic [SUM_W-1:0]  tot_e,
    input  logic [WSUM_W-1:0] tot_w,
    output logic [IDX_W-1:0]  center
);
    localparam int NUM_W = WSUM_W + 2;

    logic [NUM_W-1:0] num;
    logic [NUM_W-1:0] den;
    logic [NUM_W-1:0] quo;

    always_comb begin
        num = (NUM_W'(tot_w) << 1) + NUM_W'(tot_e) - NUM_W'(1);
        den = NUM_W'(tot_e) << 1;
        if (tot_e == '0) quo = '0;
        else             quo = num / den;
        center = IDX_W'(quo);
    end

endmodule

// File: rtl/strip_peak_finder.sv
module strip_peak_finder #(
    parameter int N_STRIPS = 36,
    parameter int E_W      = 4,
    parameter int SUM_W    = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [N_STRIPS*E_W-1:0] strip_energy,
    input  logic [E_W-1:0]          thr_strip,
    input  logic [SUM_W-1:0]        thr_peak,
    output logic                    peak_valid,
    output logic [5:0]              peak_center,
    output logic [SUM_W-1:0]        peak_energy,
    output logic                    scan_done
);
    localparam int IDX_W  = 6;
    localparam int WSUM_W = SUM_W + IDX_W;
    localparam int E_MAX  = N_STRIPS * ((1 << E_W) - 1);

    typedef struct packed {
        logic [N_STRIPS*E_W-1:0] plane;
        logic [E_W-1:0]          t0;
        logic [SUM_W-1:0]        t1;
        logic                    valid;
        logic [IDX_W-1:0]        center;
        logic [SUM_W-1:0]        energy;
    } top_t;

    top_t d, q;

    logic              load, scan_act, last_strip, close;
    logic [IDX_W-1:0]  idx, strip_num, center;
    logic [E_W-1:0]    cur_e;
    logic              active;
    logic [SUM_W-1:0]  tot_e;
    logic [WSUM_W-1:0] tot_w;

    spf_scan_ctrl #(.N_STRIPS(N_STRIPS), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .load(load),
        .scan_act(scan_act), .last_strip(last_strip), .idx(idx), .done(scan_done)
    );

    assign cur_e     = q.plane[int'(idx)*E_W +: E_W];
    assign active    = scan_act && (cur_e > q.t0);
    assign strip_num = idx + 1'b1;

    spf_run_acc #(.E_W(E_W), .SUM_W(SUM_W), .IDX_W(IDX_W), .WSUM_W(WSUM_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(load), .step(scan_act), .active(active),
        .at_edge(last_strip), .energy(cur_e), .strip_num(strip_num),
        .close(close), .tot_e(tot_e), .tot_w(tot_w)
    );

    spf_center #(.SUM_W(SUM_W), .WSUM_W(WSUM_W), .IDX_W(IDX_W)) u_ctr (
        .tot_e(tot_e), .tot_w(tot_w), .center(center)
    );

    always_comb begin
        d = q;
        if (load) begin
            d.plane = strip_energy;
            d.t0    = thr_strip;
            d.t1    = thr_peak;
        end
        d.valid  = close && (tot_e > q.t1);
        d.center = d.valid ? center : '0;
        d.energy = d.valid ? tot_e  : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign peak_valid  = q.valid;
    assign peak_center = q.center;
    assign peak_energy = q.energy;

    // Checker state: previous center reported within the current scan
    logic [IDX_W-1:0] prev_c_q;
    logic             seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_c_q <= '0;
            seen_q   <= 1'b0;
        end else if (load) begin
            seen_q   <= 1'b0;
        end else if (peak_valid) begin
            prev_c_q <= peak_center;
            seen_q   <= 1'b1;
        end
    end

    p_thr_peak_r5: assert property (@(posedge clk) disable iff (!rst_n)
        peak_valid |-> (peak_energy > q.t1));

    p_center_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        peak_valid |-> (peak_center >= 6'd1 && peak_center <= IDX_W'(N_STRIPS)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        peak_valid |-> (peak_energy <= SUM_W'(E_MAX)));

    p_ascending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (peak_valid && seen_q) |-> (peak_center > prev_c_q));

    p_done_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(peak_valid && scan_done));

endmodule

// File: tb/strip_peak_finder_bench.sv
`timescale 1ns/1ps
module strip_peak_finder_bench;
    localparam int NV = 6;

    // Strip n occupies nibble n-1 (rightmost hex digit is strip 1).
    localparam logic [143:0] VEC_E [NV] = '{
        144'h0,
        {36{4'hF}},
        144'h000000000000000000000000_343000000550,
        144'h62_0000000000000000000000000000_11000F,
        {36{4'h3}},
        {18{8'h05}}
    };
    localparam logic [3:0] VEC_T0 [NV] = '{4'd0, 4'd0, 4'd2, 4'd0, 4'd3, 4'd0};
    localparam logic [9:0] VEC_T1 [NV] = '{10'd0, 10'd0, 10'd4, 10'd2, 10'd0, 10'd4};
    localparam int         VEC_N  [NV] = '{0, 1, 2, 2, 0, 18};
    localparam string      VEC_R  [NV] = '{"R1", "R3", "R2", "R6", "R1", "R7"};

    logic         clk = 0, rst_n = 0, start = 0;
    logic [143:0] strip_energy = '0;
    logic [3:0]   thr_strip = '0;
    logic [9:0]   thr_peak = '0;
    logic         peak_valid, scan_done;
    logic [5:0]   peak_center;
    logic [9:0]   peak_energy;

    int checks = 0, errors = 0;
    int exp_n, got_n, done_at, done_cnt;
    int exp_c [36], exp_e [36], got_c [64], got_e [64];

    always #2.5 clk = ~clk;

    strip_peak_finder u_strip_peak_finder (
        .clk(clk), .rst_n(rst_n), .start(start), .strip_energy(strip_energy),
        .thr_strip(thr_strip), .thr_peak(thr_peak), .peak_valid(peak_valid),
        .peak_center(peak_center), .peak_energy(peak_energy), .scan_done(scan_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model built from the requirements
    task automatic model(input logic [143:0] v, input int t0, input int t1);
        int e, w, q, r, en;
        exp_n = 0; e = 0; w = 0;
        for (int n = 1; n <= 37; n++) begin
            en = (n <= 36) ? int'(v[(n-1)*4 +: 4]) : 0;
            if (n <= 36 && en > t0) begin
                e += en; w += n * en;
            end else if (e > 0) begin
                q = w / e; r = w - q * e;
                if (2 * r > e) q++;
                if (e > t1) begin
                    exp_c[exp_n] = q; exp_e[exp_n] = e; exp_n++;
                end
                e = 0; w = 0;
            end
        end
    endtask

    // Runs one scan; optional stray start at cycle stray_at (0 = none)
    task automatic run_scan(input logic [143:0] v, input logic [3:0] t0,
                            input logic [9:0] t1, input int stray_at, input int tail);
        got_n = 0; done_at = 0; done_cnt = 0;
        @(negedge clk);
        strip_energy = v; thr_strip = t0; thr_peak = t1; start = 1;
        @(negedge clk);
        start = 0;
        for (int k = 1; k <= 37 + tail; k++) begin
            if (k == stray_at) begin
                strip_energy = '0; thr_strip = 4'hF; start = 1;
            end
            @(negedge clk);
            start = 0;
            if (peak_valid) begin
                if (done_cnt > 0) check(0, "R8 record after done", k, 0);
                if (got_n < 64) begin got_c[got_n] = peak_center; got_e[got_n] = peak_energy; end
                got_n++;
            end
            if (scan_done) begin
                done_cnt++;
                if (done_at == 0) done_at = k;
            end
        end
    endtask

    task automatic compare(input string tag);
        check(got_n == exp_n, tag, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check(got_c[i] == exp_c[i], "R4 center", got_c[i], exp_c[i]);
            check(got_e[i] == exp_e[i], "R3 energy", got_e[i], exp_e[i]);
            if (i > 0) check(got_c[i] > got_c[i-1], "R7 order", got_c[i], got_c[i-1] + 1);
        end
        check(done_at == 37, "R8 done latency", done_at, 37);
        check(done_cnt == 1, "R8 done count", done_cnt, 1);
    endtask

    initial begin
        #(200000 * 5);
        check(0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check(peak_valid == 0 && scan_done == 0, "R10 reset flags", peak_valid, 0);
        check(peak_center == 0 && peak_energy == 0, "R10 reset data", peak_energy, 0);
        rst_n = 1;

        // Table walk: R1 floors, R2 split, R3 full plane, R4 tie, R5 filter, R6 edge, R7 order
        for (int i = 0; i < NV; i++) begin
            model(VEC_E[i], VEC_T0[i], VEC_T1[i]);
            check(exp_n == VEC_N[i], VEC_R[i], exp_n, VEC_N[i]);
            run_scan(VEC_E[i], VEC_T0[i], VEC_T1[i], 0, 3);
            compare(VEC_R[i]);
        end

        // Directed: R4 half tie on full plane rounds to 18, R3 sum 540
        run_scan({36{4'hF}}, 4'd0, 10'd0, 0, 0);
        check(got_n == 1 && got_c[0] == 18, "R4 tie down", got_c[0], 18);
        check(got_e[0] == 540, "R3 full plane", got_e[0], 540);

        // Directed: R5 total equal to floor is dropped (pair 1+1 with thr_peak 2)
        run_scan(144'h110000, 4'd0, 10'd2, 0, 0);
        check(got_n == 0, "R5 equal floor dropped", got_n, 0);
        run_scan(144'h110000, 4'd0, 10'd1, 0, 0);
        check(got_n == 1 && got_e[0] == 2, "R5 above floor kept", got_e[0], 2);

        // Directed: R6 single active strip 36 only
        run_scan({4'h9, 140'h0}, 4'd0, 10'd0, 0, 0);
        check(got_n == 1 && got_c[0] == 36, "R6 edge strip", got_c[0], 36);

        // Directed: R9 stray start mid-scan is ignored
        model(VEC_E[2], VEC_T0[2], VEC_T1[2]);
        run_scan(VEC_E[2], VEC_T0[2], VEC_T1[2], 5, 45);
        compare("R9 stray start");

        // Directed: R10 reset during a scan abandons it
        @(negedge clk);
        strip_energy = {36{4'hF}}; thr_strip = 0; thr_peak = 0; start = 1;
        @(negedge clk); start = 0;
        repeat (10) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        check(peak_valid == 0 && scan_done == 0, "R10 mid-scan reset", scan_done, 0);
        rst_n = 1;
        got_n = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (peak_valid || scan_done) got_n++;
        end
        check(got_n == 0, "R10 no activity after reset", got_n, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule